// File: doc/BRIEF.md
# Iterative Integer Word Divider

This block divides one word-sized integer by another, either as signed or as unsigned numbers, and returns the quotient only. A caller presents the dividend, the divisor, a signedness select and an overflow-report select, then pulses `start` for one cycle. The block answers with a one-cycle `done` strobe. Alongside that strobe it presents the quotient and an overflow flag, and both stay unchanged until the next result.

Ordinary divisions produce one quotient bit per cycle with a restoring shift-subtract loop. The loop works on magnitudes. The sign is applied once at the end, so signed results truncate toward zero. Two operand patterns have no ordinary answer: any divisor of zero, and, in signed mode, the most negative value divided by minus one. For these the block skips the loop, finishes in a single cycle and returns a quotient of zero. It raises the overflow flag for them only when the overflow-report select is high.

Top module: `word_divider`

## Requirements
- R1: In unsigned mode (`isSigned`=0) with a nonzero divisor, the quotient equals the integer floor of dividend over divisor, both read as unsigned.
- R2: In signed mode (`isSigned`=1) the operands are two's complement. Outside the exceptional cases the quotient is the true quotient truncated toward zero: it is negative when the operand signs differ and positive or zero when they match.
- R3: A divisor of zero yields a quotient of 0 in both modes.
- R4: In signed mode, a dividend with only the top bit set divided by an all-ones divisor yields a quotient of 0. In unsigned mode the same operands are an ordinary division.
- R5: `overflow` is 1 with a result only when that result came from an exceptional case (R3 or R4) and `ovfEn` was 1 at start. It is 0 with every other result.
- R6: For an ordinary division, `done` is high in exactly one cycle: the one that follows the WIDTH+1-th rising edge after the edge that accepted `start`.
- R7: For an exceptional case, `done` is high in the cycle right after the accepting edge.
- R8: A `start` pulse that arrives while `busy` is high is ignored. It does not change the result, the timing or the number of `done` pulses of the division in progress.
- R9: After reset, `done`, `busy`, `overflow` and `quotient` are all 0.
- R10: `busy` is 1 from the cycle after an accepted ordinary start until, but not including, the cycle in which `done` is high. An exceptional start never raises `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a division with the current operands |
| dividend | input | WIDTH | Numerator |
| divisor | input | WIDTH | Denominator |
| isSigned | input | 1 | 1 = two's complement operands, 0 = unsigned |
| ovfEn | input | 1 | 1 = report exceptional cases on `overflow` |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle strobe: result is valid |
| quotient | output | WIDTH | Result, held until the next result |
| overflow | output | 1 | Exceptional case reported, held with the result |

## Verification
The embedded properties check on every cycle that the iteration counter steps by one without skipping, that no load or short-cut can occur while the loop runs, and that `busy` drops when the fix-up stage ends. They also check that an exceptional start gives a zero quotient on the next cycle, and that a raised overflow is always paired with a zero quotient. The arithmetic itself can only be shown by the bench scenarios. These cover truncation toward zero for every sign pairing, unsigned versus signed reading of the same bits, and the exact cycle of `done`. The bench compares these against quotients computed independently, over an exhaustive sweep of a 4-bit instance and directed 32-bit corners. It also checks that a second request made mid-division leaves the running result untouched.

// File: rtl/word_div_pkg.sv
package word_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } divState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture magnitudes, clear partial remainder
    logic step;    // one shift-subtract iteration
    logic finish;  // apply sign and publish the quotient
    logic except;  // publish the zero result of an exceptional case
  } divStrobe_t;

endpackage

// File: rtl/word_div_ctrl.sv
module word_div_ctrl
  import word_div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       isExc,
  output logic       busy,
  output divStrobe_t strobe
);

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  divState_t     state, stateNext;
  logic [CW-1:0] iterCnt;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (isExc) begin
            strobe.except = 1'b1;
          end else begin
            strobe.load = 1'b1;
            stateNext   = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        strobe.step = 1'b1;
        if (iterCnt == LAST) stateNext = ST_FIX;
      end
      ST_FIX: begin
        strobe.finish = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.load)      iterCnt <= '0;
      else if (strobe.step) iterCnt <= iterCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

  // the loop never skips or repeats an iteration
  assert_count_advance_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && iterCnt != LAST) |=> (state == ST_RUN && iterCnt == $past(iterCnt) + CW'(1)));

  // no new request is taken while a division runs
  assert_no_reload_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!strobe.load && !strobe.except));

  // fix-up is the last busy cycle
  assert_busy_ends_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIX) |=> !busy);

endmodule

// File: rtl/word_div_path.sv
module word_div_path
  import word_div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             isSigned,
  input  logic             ovfEn,
  input  divStrobe_t       strobe,
  output logic             isExc,
  output logic [WIDTH-1:0] quotient,
  output logic             done,
  output logic             overflow
);

  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic             divZero, minByMinusOne, negA, negB;
  logic [WIDTH-1:0] magA, magB;
  logic [WIDTH-1:0] remR, quoR, divR;
  logic             negR;
  logic [WIDTH:0]   shifted, trial;

  // operand screening
  assign divZero       = (opB == '0);
  assign minByMinusOne = isSigned && (opA == MOST_NEG) && (opB == ALL_ONES);
  assign isExc         = divZero || minByMinusOne;

  assign negA = isSigned && opA[WIDTH-1];
  assign negB = isSigned && opB[WIDTH-1];
  assign magA = negA ? (~opA + 1'b1) : opA;
  assign magB = negB ? (~opB + 1'b1) : opB;

  // restoring shift-subtract step
  assign shifted = {remR, quoR[WIDTH-1]};
  assign trial   = shifted - {1'b0, divR};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR <= '0;
      quoR <= '0;
      divR <= '0;
      negR <= 1'b0;
    end else if (strobe.load) begin
      remR <= '0;
      quoR <= magA;
      divR <= magB;
      negR <= negA ^ negB;
    end else if (strobe.step) begin
      if (!trial[WIDTH]) begin
        remR <= trial[WIDTH-1:0];
        quoR <= {quoR[WIDTH-2:0], 1'b1};
      end else begin
        remR <= shifted[WIDTH-1:0];
        quoR <= {quoR[WIDTH-2:0], 1'b0};
      end
    end
  end

  // result stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      quotient <= '0;
      overflow <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= strobe.finish || strobe.except;
      if (strobe.except) begin
        quotient <= '0;
        overflow <= ovfEn;
      end else if (strobe.finish) begin
        quotient <= negR ? (~quoR + 1'b1) : quoR;
        overflow <= 1'b0;
      end
    end
  end

  // an exceptional start publishes zero on the next cycle
  assert_zero_result_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.except |=> (done && quotient == '0));

  // overflow only accompanies a zero exceptional result
  assert_ovf_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && overflow) |-> (quotient == '0));

  // a step never happens on the same cycle as a load
  assert_step_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.load, strobe.step, strobe.finish, strobe.except}) <= 1);

endmodule

// File: rtl/word_divider.sv
module word_divider
  import word_div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             isSigned,
  input  logic             ovfEn,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic             overflow
);

  divStrobe_t strobe;
  logic       isExc;

  word_div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .isExc  (isExc),
    .busy   (busy),
    .strobe (strobe)
  );

  word_div_path #(.WIDTH(WIDTH)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .opA      (dividend),
    .opB      (divisor),
    .isSigned (isSigned),
    .ovfEn    (ovfEn),
    .strobe   (strobe),
    .isExc    (isExc),
    .quotient (quotient),
    .done     (done),
    .overflow (overflow)
  );

endmodule

// File: tb/word_divider_bench.sv
module word_divider_bench;

  localparam int SW = 4;
  localparam int WW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // small exhaustive instance
  logic          sStart = 0, sSigned = 0, sOvfEn = 0;
  logic [SW-1:0] sA = '0, sB = '0;
  logic          sBusy, sDone, sOvf;
  logic [SW-1:0] sQ;

  // full-width directed instance
  logic          wStart = 0, wSigned = 0, wOvfEn = 0;
  logic [WW-1:0] wA = '0, wB = '0;
  logic          wBusy, wDone, wOvf;
  logic [WW-1:0] wQ;

  word_divider #(.WIDTH(SW)) u_word_divider (
    .clk(clk), .rstN(rstN), .start(sStart), .dividend(sA), .divisor(sB),
    .isSigned(sSigned), .ovfEn(sOvfEn), .busy(sBusy), .done(sDone),
    .quotient(sQ), .overflow(sOvf));

  word_divider #(.WIDTH(WW)) u_wide (
    .clk(clk), .rstN(rstN), .start(wStart), .dividend(wA), .divisor(wB),
    .isSigned(wSigned), .ovfEn(wOvfEn), .busy(wBusy), .done(wDone),
    .quotient(wQ), .overflow(wOvf));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit isExcCase(longint a, longint b, bit sg, int w);
    longint mask = (longint'(1) << w) - 1;
    longint minNeg = longint'(1) << (w - 1);
    return (b == 0) || (sg && a == minNeg && b == mask);
  endfunction

  function automatic longint expQuot(longint a, longint b, bit sg, int w);
    longint mask = (longint'(1) << w) - 1;
    longint sa, sb;
    if (isExcCase(a, b, sg, w)) return 0;
    if (!sg) return (a / b) & mask;
    sa = a[w-1] ? a - (longint'(1) << w) : a;
    sb = b[w-1] ? b - (longint'(1) << w) : b;
    return (sa / sb) & mask;   // truncates toward zero
  endfunction

  task automatic runSmall(input int a, input int b, input bit sg, input bit oe);
    int cyc;
    bit exc = isExcCase(a, b, sg, SW);
    string req = exc ? (b == 0 ? "R3" : "R4") : (sg ? "R2" : "R1");
    @(negedge clk);
    sA = SW'(a); sB = SW'(b); sSigned = sg; sOvfEn = oe; sStart = 1;
    @(negedge clk);
    sStart = 0; cyc = 1;
    while (!sDone && cyc < 40) begin @(negedge clk); cyc++; end
    check(sQ == SW'(expQuot(a, b, sg, SW)), req, "quotient", sQ, expQuot(a, b, sg, SW));
    check(sOvf == (exc && oe), "R5", "overflow", sOvf, exc && oe);
    check(cyc == (exc ? 1 : SW + 2), exc ? "R7" : "R6", "latency", cyc, exc ? 1 : SW + 2);
  endtask

  task automatic runWide(input logic [WW-1:0] a, input logic [WW-1:0] b,
                         input bit sg, input bit oe, input string req);
    int cyc;
    bit exc = isExcCase(longint'(a), longint'(b), sg, WW);
    longint e = expQuot(longint'(a), longint'(b), sg, WW);
    @(negedge clk);
    wA = a; wB = b; wSigned = sg; wOvfEn = oe; wStart = 1;
    @(negedge clk);
    wStart = 0; cyc = 1;
    check(wBusy == !exc, "R10", "busy after start", wBusy, !exc);
    while (!wDone && cyc < 80) begin @(negedge clk); cyc++; end
    check(wQ == WW'(e), req, "quotient", wQ, e);
    check(wOvf == (exc && oe), "R5", "overflow", wOvf, exc && oe);
    check(cyc == (exc ? 1 : WW + 2), exc ? "R7" : "R6", "latency", cyc, exc ? 1 : WW + 2);
    check(wBusy == 0, "R10", "busy at done", wBusy, 0);
    @(negedge clk);
    check(wDone == 0, "R6", "done single pulse", wDone, 0);
    check(wQ == WW'(e), req, "quotient held", wQ, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(sDone == 0 && sBusy == 0, "R9", "small done/busy", {sDone, sBusy}, 0);
    check(sQ == 0 && sOvf == 0, "R9", "small quotient/ovf", {sOvf, sQ}, 0);
    check(wDone == 0 && wBusy == 0, "R9", "wide done/busy", {wDone, wBusy}, 0);
    check(wQ == 0 && wOvf == 0, "R9", "wide quotient/ovf", {wOvf, wQ}, 0);
    rstN = 1;

    // exhaustive 4-bit sweep: R1 R2 R3 R4 R5 R6 R7
    for (int sg = 0; sg < 2; sg++)
      for (int oe = 0; oe < 2; oe++)
        for (int a = 0; a < (1 << SW); a++)
          for (int b = 0; b < (1 << SW); b++)
            runSmall(a, b, sg[0], oe[0]);

    // full-width corners
    runWide(32'd100, 32'd7, 0, 0, "R1");
    runWide(32'hFFFFFFFF, 32'd1, 0, 1, "R1");
    runWide(32'hFFFFFFFF, 32'hFFFFFFFE, 0, 0, "R1");
    runWide(-32'sd100, 32'd7, 1, 0, "R2");
    runWide(32'd7, -32'sd2, 1, 0, "R2");
    runWide(-32'sd7, 32'd2, 1, 1, "R2");
    runWide(-32'sd8, -32'sd2, 1, 0, "R2");
    runWide(32'h12345678, 32'd0, 0, 0, "R3");
    runWide(32'h12345678, 32'd0, 1, 1, "R3");
    runWide(32'h80000000, 32'hFFFFFFFF, 1, 0, "R4");
    runWide(32'h80000000, 32'hFFFFFFFF, 1, 1, "R4");
    runWide(32'h80000000, 32'hFFFFFFFF, 0, 1, "R4");   // unsigned: ordinary
    runWide(32'h80000000, 32'd1, 1, 1, "R2");

    // R8: requests during a running division are ignored
    begin
      int cyc = 0;
      int pulses = 0;
      @(negedge clk);
      wA = 32'd1000; wB = 32'd9; wSigned = 0; wOvfEn = 1; wStart = 1;
      @(negedge clk); wStart = 0; cyc = 1;
      repeat (4) begin @(negedge clk); cyc++; end
      wA = 32'd5; wB = 32'd0; wStart = 1;          // exceptional request
      @(negedge clk); wStart = 0; cyc++;
      check(wDone == 0, "R8", "no early done", wDone, 0);
      wA = 32'd77; wB = 32'd3; wStart = 1;          // ordinary request
      @(negedge clk); wStart = 0; cyc++;
      while (!wDone && cyc < 80) begin @(negedge clk); cyc++; end
      check(cyc == WW + 2, "R8", "latency kept", cyc, WW + 2);
      check(wQ == 32'd111, "R8", "quotient kept", wQ, 111);
      check(wOvf == 0, "R8", "overflow kept", wOvf, 0);
      repeat (WW + 4) begin @(negedge clk); if (wDone) pulses++; end
      check(pulses == 0, "R8", "no extra done", pulses, 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule